// File: doc/BRIEF.md
# Offset, Gain and Saturation Output Stage

This block is the last arithmetic step of one audio channel. Each time a signed 24-bit filtered sample arrives with its strobe, the block adds a programmable offset that is weighted by 2^8. It multiplies the corrected value by an unsigned gain and keeps the 32 most significant bits of the 40-bit product.

A mode input then selects one of two outputs. The first is the 32-bit value as it stands. The second is an arithmetic right shift of that value by `scale_sel + shift_sel + 8`, clamped to a symmetric signed 16-bit range and sign-extended to 32 bits. The result appears with its own strobe two cycles after the input strobe.

The configuration inputs (offset, gain, the two shift fields and the mode) may change at any time. Only the values present in the cycle that carries an input strobe are used for that sample.

Top module: `ogs_top`

## Requirements
- R1: The offset-corrected sum is `sample_in + offset_in * 256`, computed at 25 bits with no wrap.
- R2: In word mode (`word_mode` = 1) the output is bits 39..8 of the 40-bit signed product of the sum and `gain_in`. This equals the product shifted right arithmetically by 8.
- R3: In half mode (`word_mode` = 0) the retained 32-bit value is shifted right arithmetically by `scale_sel + shift_sel + 8`. The shift amount can reach 38.
- R4: In half mode the shifted value is clamped to the range -32767 to +32767. The code -32768 never appears in bits 15..0.
- R5: In half mode bits 31..16 of `result_out` all equal bit 15.
- R6: When `gain_in` is 0 the result is 0 in both modes.
- R7: `result_valid` is high for exactly one cycle, two clock edges after the edge that samples `sample_valid`. It is never high otherwise.
- R8: Configuration inputs are captured only on the edge that samples `sample_valid`. Changing them afterwards does not alter that sample's result.
- R9: `result_out` holds its value while `result_valid` is low.
- R10: After synchronous reset `result_valid` and `result_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Strobe for `sample_in` |
| sample_in | input | 24 | Signed filtered sample |
| offset_in | input | 16 | Signed offset, weighted by 2^8 |
| gain_in | input | 15 | Unsigned gain |
| scale_sel | input | 4 | First shift field |
| shift_sel | input | 4 | Second shift field |
| word_mode | input | 1 | 1 selects 32-bit output, 0 selects clamped 16-bit output |
| result_valid | output | 1 | Result strobe |
| result_out | output | 32 | Result word |

## Verification
The bench sweeps every pair of shift fields in both modes against an arithmetic model. This exposes an adder that wraps at 4 bits, a missing +8, or a logical shift that turns negative values positive. Full-scale positive and negative inputs drive the clamp to both rails. A design that lets -32768 through or clamps asymmetrically fails there, as does one that truncates without clamping and so returns a wrapped value. Zero gain, offset-only inputs and configuration changed straight after the strobe check, respectively, a product taken from the wrong bit slice and configuration that is used live instead of captured.

// File: rtl/ogs_pkg.sv
`timescale 1ns/1ps
package ogs_pkg;

    parameter int FIELD_W    = 4;
    parameter int BASE_SHIFT = 8;
    parameter int SHAMT_MAX  = 2 * ((1 << FIELD_W) - 1) + BASE_SHIFT;
    parameter int SHAMT_W    = $clog2(SHAMT_MAX + 1);

    typedef enum logic {
        RES_HALF = 1'b0,
        RES_WORD = 1'b1
    } res_mode_e;

    typedef struct packed {
        res_mode_e          mode;
        logic [SHAMT_W-1:0] shamt;
    } post_cfg_t;

    function automatic logic [SHAMT_W-1:0] total_shift(
        input logic [FIELD_W-1:0] a,
        input logic [FIELD_W-1:0] b
    );
        return SHAMT_W'(a) + SHAMT_W'(b) + SHAMT_W'(BASE_SHIFT);
    endfunction

endpackage

// File: rtl/ogs_gain_mult.sv
`timescale 1ns/1ps
module ogs_gain_mult #(
    parameter int SAMPLE_W  = 24,
    parameter int OFS_W     = 16,
    parameter int GAIN_W    = 15,
    parameter int KEEP_W    = 32,
    parameter int OFS_SHIFT = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic signed [SAMPLE_W-1:0] din,
    input  logic signed [OFS_W-1:0]    ofs,
    input  logic        [GAIN_W-1:0]   gain,
    output logic                       prod_valid,
    output logic signed [KEEP_W-1:0]   prod_top
);
    localparam int WIDER  = (SAMPLE_W > OFS_W + OFS_SHIFT) ? SAMPLE_W : OFS_W + OFS_SHIFT;
    localparam int SUM_W  = WIDER + 1;
    localparam int PROD_W = SUM_W + GAIN_W;
    localparam int DROP   = PROD_W - KEEP_W;

    logic signed [SUM_W-1:0]  din_x, ofs_x, sum;
    logic signed [GAIN_W:0]   gain_s;
    logic signed [PROD_W-1:0] prod;

    always_comb begin
        din_x  = SUM_W'(din);
        ofs_x  = SUM_W'(ofs) <<< OFS_SHIFT;
        sum    = din_x + ofs_x;
        gain_s = {1'b0, gain};
        prod   = PROD_W'(sum) * PROD_W'(gain_s);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_valid <= 1'b0;
            prod_top   <= '0;
        end else begin
            prod_valid <= in_valid;
            if (in_valid)
                prod_top <= KEEP_W'(prod >>> DROP);
        end
    end
endmodule

// File: rtl/ogs_scale_sat.sv
`timescale 1ns/1ps
module ogs_scale_sat
    import ogs_pkg::*;
#(
    parameter int KEEP_W = 32,
    parameter int HALF_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic signed [KEEP_W-1:0] prod_top,
    input  post_cfg_t                cfg,
    output logic                     out_valid,
    output logic        [KEEP_W-1:0] out_data
);
    localparam logic signed [KEEP_W-1:0] HI = KEEP_W'((64'sd1 <<< (HALF_W - 1)) - 64'sd1);
    localparam logic signed [KEEP_W-1:0] LO = -HI;

    logic signed [KEEP_W-1:0] shifted, clamped, result;

    always_comb begin
        shifted = prod_top >>> cfg.shamt;
        if (shifted > HI)
            clamped = HI;
        else if (shifted < LO)
            clamped = LO;
        else
            clamped = shifted;
        result = (cfg.mode == RES_WORD) ? prod_top : clamped;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                out_data <= result;
        end
    end
endmodule

// File: rtl/ogs_top.sv
`timescale 1ns/1ps
module ogs_top
    import ogs_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int OFS_W    = 16,
    parameter int GAIN_W   = 15,
    parameter int KEEP_W   = 32,
    parameter int HALF_W   = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sample_valid,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic [OFS_W-1:0]    offset_in,
    input  logic [GAIN_W-1:0]   gain_in,
    input  logic [FIELD_W-1:0]  scale_sel,
    input  logic [FIELD_W-1:0]  shift_sel,
    input  logic                word_mode,
    output logic                result_valid,
    output logic [KEEP_W-1:0]   result_out
);
    logic                     mid_valid;
    logic signed [KEEP_W-1:0] mid_top;
    post_cfg_t                cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (sample_valid) begin
            cfg_q.mode  <= word_mode ? RES_WORD : RES_HALF;
            cfg_q.shamt <= total_shift(scale_sel, shift_sel);
        end
    end

    ogs_gain_mult #(
        .SAMPLE_W (SAMPLE_W),
        .OFS_W    (OFS_W),
        .GAIN_W   (GAIN_W),
        .KEEP_W   (KEEP_W),
        .OFS_SHIFT(BASE_SHIFT)
    ) u_mult (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (sample_valid),
        .din       (signed'(sample_in)),
        .ofs       (signed'(offset_in)),
        .gain      (gain_in),
        .prod_valid(mid_valid),
        .prod_top  (mid_top)
    );

    ogs_scale_sat #(
        .KEEP_W(KEEP_W),
        .HALF_W(HALF_W)
    ) u_sat (
        .clk      (clk),
        .rst      (rst),
        .in_valid (mid_valid),
        .prod_top (mid_top),
        .cfg      (cfg_q),
        .out_valid(result_valid),
        .out_data (result_out)
    );
endmodule

// File: rtl/ogs_checker.sv
`timescale 1ns/1ps
module ogs_checker #(
    parameter int GAIN_W = 15,
    parameter int KEEP_W = 32,
    parameter int HALF_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              sample_valid,
    input logic [GAIN_W-1:0] gain_in,
    input logic              word_mode,
    input logic              result_valid,
    input logic [KEEP_W-1:0] result_out
);
    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> $past(sample_valid, 2)); // R7

    AST_HALF_SIGNEXT: assert property (@(posedge clk) disable iff (rst)
        (result_valid && !$past(word_mode, 2))
        |-> (result_out[KEEP_W-1:HALF_W] == {(KEEP_W-HALF_W){result_out[HALF_W-1]}})); // R5

    AST_HALF_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (result_valid && !$past(word_mode, 2))
        |-> (result_out[HALF_W-1:0] != {1'b1, {(HALF_W-1){1'b0}}})); // R4

    AST_ZERO_GAIN: assert property (@(posedge clk) disable iff (rst)
        (result_valid && ($past(gain_in, 2) == '0)) |-> (result_out == '0)); // R6

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !result_valid |-> $stable(result_out)); // R9
endmodule

bind ogs_top ogs_checker #(
    .GAIN_W(GAIN_W),
    .KEEP_W(KEEP_W),
    .HALF_W(HALF_W)
) u_ogs_chk (
    .clk         (clk),
    .rst         (rst),
    .sample_valid(sample_valid),
    .gain_in     (gain_in),
    .word_mode   (word_mode),
    .result_valid(result_valid),
    .result_out  (result_out)
);

// File: tb/test_ogs_top.sv
`timescale 1ns/1ps
module test_ogs_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        sample_valid;
    logic [23:0] sample_in;
    logic [15:0] offset_in;
    logic [14:0] gain_in;
    logic [3:0]  scale_sel, shift_sel;
    logic        word_mode;
    logic        result_valid;
    logic [31:0] result_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    ogs_top i_ogs_top (
        .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample_in(sample_in),
        .offset_in(offset_in), .gain_in(gain_in), .scale_sel(scale_sel),
        .shift_sel(shift_sel), .word_mode(word_mode),
        .result_valid(result_valid), .result_out(result_out)
    );

    function automatic logic [31:0] model(input logic [23:0] d, input logic [15:0] o,
                                          input logic [14:0] g, input int sc, input int sh,
                                          input logic wm);
        longint s, p, top, v;
        s   = longint'(signed'(d)) + longint'(signed'(o)) * 256;
        p   = s * longint'(g);
        top = p >>> 8;
        if (wm) return top[31:0];
        v = top >>> (sc + sh + 8);
        if (v > 32767) v = 32767;
        if (v < -32767) v = -32767;
        return v[31:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_one(input string req, input logic [23:0] d, input logic [15:0] o,
                           input logic [14:0] g, input int sc, input int sh, input logic wm);
        logic [31:0] exp;
        exp = model(d, o, g, sc, sh, wm);
        @(negedge clk);
        sample_in = d; offset_in = o; gain_in = g;
        scale_sel = 4'(sc); shift_sel = 4'(sh); word_mode = wm;
        sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
        // R8: scramble configuration after the capture edge
        sample_in = 24'($urandom); offset_in = 16'($urandom); gain_in = 15'($urandom);
        scale_sel = 4'($urandom); shift_sel = 4'($urandom); word_mode = ~wm;
        check("R7 no early valid", {31'd0, result_valid}, 32'd0);
        @(negedge clk);
        check("R7 valid at latency 2", {31'd0, result_valid}, 32'd1);
        check(req, result_out, exp);
        @(negedge clk);
        check("R7 single-cycle valid", {31'd0, result_valid}, 32'd0);
        check("R9 hold while idle", result_out, exp);
    endtask

    initial begin
        #(8ns * 190000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; sample_valid = 1'b0; sample_in = '0; offset_in = '0;
        gain_in = '0; scale_sel = '0; shift_sel = '0; word_mode = 1'b0;
        repeat (3) @(negedge clk);
        check("R10 reset valid", {31'd0, result_valid}, 32'd0);
        check("R10 reset data", result_out, 32'd0);
        rst = 1'b0;

        run_one("R1 offset weight", 24'd0, 16'd1, 15'd1, 0, 0, 1'b1);
        run_one("R1 negative offset", 24'd0, 16'hFFFF, 15'd1, 0, 0, 1'b1);
        run_one("R2 positive full scale", 24'h7FFFFF, 16'h7FFF, 15'h7FFF, 0, 0, 1'b1);
        run_one("R2 negative full scale", 24'h800000, 16'h8000, 15'h7FFF, 0, 0, 1'b1);
        run_one("R4 clamp high", 24'h7FFFFF, 16'h7FFF, 15'h7FFF, 0, 0, 1'b0);
        run_one("R4 clamp low", 24'h800000, 16'h8000, 15'h7FFF, 0, 0, 1'b0);
        run_one("R4 clamp low near rail", 24'h800000, 16'h0000, 15'h4000, 0, 0, 1'b0);
        run_one("R6 zero gain half", 24'h7FFFFF, 16'h7FFF, 15'd0, 3, 2, 1'b0);
        run_one("R6 zero gain word", 24'h800000, 16'h1234, 15'd0, 0, 0, 1'b1);
        run_one("R3 max shift negative", 24'h800000, 16'h8000, 15'h7FFF, 15, 15, 1'b0);
        run_one("R5 negative half", 24'hFFF000, 16'h0000, 15'h0100, 0, 0, 1'b0);

        for (int sc = 0; sc < 16; sc++)
            for (int sh = 0; sh < 16; sh++)
                for (int m = 0; m < 2; m++)
                    for (int k = 0; k < 2; k++)
                        run_one(m == 1 ? "R2 sweep word" : "R3 sweep half",
                                24'($urandom), 16'($urandom), 15'($urandom_range(1, 32767)),
                                sc, sh, 1'(m));

        for (int i = 0; i < 1500; i++)
            run_one("R3 random", 24'($urandom), 16'($urandom), 15'($urandom),
                    int'($urandom_range(0, 15)), int'($urandom_range(0, 15)), 1'($urandom));

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule